// File: doc/BRIEF.md
# Card Power Class Register

This block keeps the power class that a managed flash card is allowed to draw. A byte-wide class register is loaded by a switch-style write strobe that carries the requested value. Beside it sits a fixed table of supported power levels, one byte per combination of bus width (4-bit or 8-bit) and clock rate (26 MHz or 52 MHz), which the host reads back to decide how high a class it will permit.

A request is accepted only when it fits the 4-bit class field and does not exceed the highest class found in the table. A request that fails either test leaves the stored class as it was and raises a sticky switch-error flag. The flag stays up until a status read, a reset or a software reset clears it. Both the reset input and the software-reset strobe return the class to 0, the lowest-consumption level.

Top module: `power_class_reg`

## Requirements
- R1: While `rst_n` is low, and on the first sampled cycle after it rises, `pwr_class` is 0 and `switch_err` is 0.
- R2: A `soft_rst` pulse sets `pwr_class` to 0 and `switch_err` to 0 on the next clock edge, and it wins over a write or a status read in the same cycle.
- R3: A write (`wr_en` high) whose `wr_data` is at most 15 and at most the largest table class loads `pwr_class` with `wr_data` on the next edge and leaves `switch_err` as it was.
- R4: A write whose `wr_data` is above 15 leaves `pwr_class` unchanged and sets `switch_err` on the next edge.
- R5: A write whose `wr_data` is at most 15 but above the largest table class leaves `pwr_class` unchanged and sets `switch_err`; `pwr_class` never exceeds the largest table class.
- R6: `switch_err` stays set until a `stat_rd` pulse clears it on the next edge; a rejected write in the same cycle as `stat_rd` keeps it set.
- R7: `tbl_data` shows, in the same cycle, the table entry picked by index {`tbl_fast`,`tbl_wide`}: 0 = 4-bit/26 MHz, 1 = 8-bit/26 MHz, 2 = 4-bit/52 MHz, 3 = 8-bit/52 MHz. The class of an entry is its low 4 bits; the default entries are 0x01, 0x02, 0x03, 0x05.
- R8: With `wr_en` and `soft_rst` low, `pwr_class` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| soft_rst | input | 1 | Software-reset strobe |
| wr_en | input | 1 | Switch write strobe for the class byte |
| wr_data | input | 8 | Requested class value |
| stat_rd | input | 1 | Status read strobe, clears the error flag |
| tbl_wide | input | 1 | Table select: 1 = 8-bit bus, 0 = 4-bit bus |
| tbl_fast | input | 1 | Table select: 1 = 52 MHz, 0 = 26 MHz |
| tbl_data | output | 8 | Selected power table entry |
| pwr_class | output | 8 | Stored power class |
| switch_err | output | 1 | Sticky switch-error flag |

## Verification
The hardest situations are the same-cycle collisions: a rejected write arriving with a status read, and a software reset arriving with a valid write, since each needs two strobes raised on one edge. The bench builds these by driving both strobes in one task on the same falling edge and checking the flag and class one cycle later. The table boundary is reached by writing exactly the largest table class and then one above it, which separates the table limit from the 15 field limit.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned N_ENT  = 4;
  localparam int unsigned IDX_W  = $clog2(N_ENT);

  typedef logic [BYTE_W-1:0] byte_t;

  // Table position from bus width and clock rate selects.
  function automatic logic [IDX_W-1:0] tbl_index(input logic wide, input logic fast);
    return {fast, wide};
  endfunction

  // A request must fit both the field limit and the table limit.
  function automatic logic req_valid(input byte_t req, input byte_t field_max, input byte_t tbl_max);
    return (req <= field_max) && (req <= tbl_max);
  endfunction
endpackage

// File: rtl/pcr_table.sv
module pcr_table
  import pcr_pkg::*;
#(
  parameter byte_t ENT_4B26 = 8'h01,
  parameter byte_t ENT_8B26 = 8'h02,
  parameter byte_t ENT_4B52 = 8'h03,
  parameter byte_t ENT_8B52 = 8'h05
) (
  input  logic             sel_wide,
  input  logic             sel_fast,
  output byte_t            rd_data,
  output byte_t            max_cls
);
  localparam byte_t ENTRIES [N_ENT] = '{ENT_4B26, ENT_8B26, ENT_4B52, ENT_8B52};

  logic [NIB_W-1:0] run_max [N_ENT+1];
  assign run_max[0] = '0;

  for (genvar g = 0; g < N_ENT; g++) begin : g_max
    localparam logic [NIB_W-1:0] CLS = ENTRIES[g][NIB_W-1:0];
    assign run_max[g+1] = (CLS > run_max[g]) ? CLS : run_max[g];
  end

  assign max_cls = byte_t'(run_max[N_ENT]);
  assign rd_data = ENTRIES[tbl_index(sel_wide, sel_fast)];
endmodule

// File: rtl/pcr_check.sv
module pcr_check
  import pcr_pkg::*;
#(
  parameter byte_t FIELD_MAX = 8'd15
) (
  input  logic  wr_en,
  input  byte_t wr_data,
  input  byte_t max_cls,
  output logic  wr_good,
  output logic  wr_bad
);
  logic ok;
  assign ok      = req_valid(wr_data, FIELD_MAX, max_cls);
  assign wr_good = wr_en && ok;
  assign wr_bad  = wr_en && !ok;
endmodule

// File: rtl/pcr_store.sv
module pcr_store
  import pcr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  soft_rst,
  input  logic  wr_good,
  input  logic  wr_bad,
  input  byte_t wr_data,
  input  logic  stat_rd,
  output byte_t cls_q,
  output logic  err_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      cls_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (wr_good) cls_q <= wr_data;
      if (wr_bad)       err_q <= 1'b1;
      else if (stat_rd) err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/power_class_reg.sv
module power_class_reg
  import pcr_pkg::*;
#(
  parameter byte_t FIELD_MAX = 8'd15,
  parameter byte_t ENT_4B26  = 8'h01,
  parameter byte_t ENT_8B26  = 8'h02,
  parameter byte_t ENT_4B52  = 8'h03,
  parameter byte_t ENT_8B52  = 8'h05
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       stat_rd,
  input  logic       tbl_wide,
  input  logic       tbl_fast,
  output logic [7:0] tbl_data,
  output logic [7:0] pwr_class,
  output logic       switch_err
);
  byte_t max_cls;
  logic  wr_good;
  logic  wr_bad;

  pcr_table #(
    .ENT_4B26(ENT_4B26), .ENT_8B26(ENT_8B26),
    .ENT_4B52(ENT_4B52), .ENT_8B52(ENT_8B52)
  ) u_table (
    .sel_wide(tbl_wide), .sel_fast(tbl_fast),
    .rd_data(tbl_data), .max_cls(max_cls)
  );

  pcr_check #(.FIELD_MAX(FIELD_MAX)) u_check (
    .wr_en(wr_en), .wr_data(wr_data), .max_cls(max_cls),
    .wr_good(wr_good), .wr_bad(wr_bad)
  );

  pcr_store u_store (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_good(wr_good), .wr_bad(wr_bad), .wr_data(wr_data),
    .stat_rd(stat_rd), .cls_q(pwr_class), .err_q(switch_err)
  );
endmodule

// File: rtl/pcr_props.sv
module pcr_props (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       stat_rd,
  input logic       wr_good,
  input logic       wr_bad,
  input logic [7:0] max_cls,
  input logic [7:0] pwr_class,
  input logic       switch_err
);
  p_soft_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (pwr_class == 8'd0) && !switch_err);

  p_good_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_good && !soft_rst && !stat_rd) |=>
      (pwr_class == $past(wr_data)) && (switch_err == $past(switch_err)));

  p_bad_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bad && !soft_rst) |=> $stable(pwr_class) && switch_err);

  p_class_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_class <= max_cls);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (switch_err && !stat_rd && !soft_rst) |=> switch_err);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !soft_rst) |=> $stable(pwr_class));
endmodule

bind power_class_reg pcr_props u_props (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
  .wr_data(wr_data), .stat_rd(stat_rd), .wr_good(wr_good), .wr_bad(wr_bad),
  .max_cls(max_cls), .pwr_class(pwr_class), .switch_err(switch_err)
);

// File: tb/test_power_class_reg.sv
module test_power_class_reg;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, soft_rst, wr_en, stat_rd, tbl_wide, tbl_fast;
  logic [7:0] wr_data, tbl_data, pwr_class;
  logic       switch_err;
  int         total = 0;
  int         bad = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  power_class_reg i_power_class_reg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .wr_data(wr_data), .stat_rd(stat_rd), .tbl_wide(tbl_wide),
    .tbl_fast(tbl_fast), .tbl_data(tbl_data), .pwr_class(pwr_class),
    .switch_err(switch_err)
  );

  // Largest class among the default entries 1,2,3,5.
  localparam logic [7:0] TOP_CLS = 8'd5;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    soft_rst = 0; wr_en = 0; stat_rd = 0; wr_data = 8'h00;
  endtask

  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_write(input logic [7:0] v);
    wr_en = 1; wr_data = v;
    step();
  endtask

  task automatic t_reset();
    rst_n = 0; idle_inputs(); tbl_wide = 0; tbl_fast = 0;
    repeat (2) @(negedge clk);
    chk("R1 class in reset", pwr_class, 8'd0);
    chk("R1 err in reset", {7'd0, switch_err}, 8'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 class after reset", pwr_class, 8'd0);
    chk("R1 err after reset", {7'd0, switch_err}, 8'd0);
  endtask

  task automatic t_table();
    logic [7:0] exp_tbl [4] = '{8'h01, 8'h02, 8'h03, 8'h05};
    for (int i = 0; i < 4; i++) begin
      tbl_wide = i[0]; tbl_fast = i[1];
      #1;
      chk("R7 table entry", tbl_data, exp_tbl[i]);
    end
  endtask

  task automatic t_valid();
    do_write(8'd3);
    chk("R3 class load 3", pwr_class, 8'd3);
    chk("R3 err unchanged", {7'd0, switch_err}, 8'd0);
    do_write(TOP_CLS);
    chk("R3 class load top", pwr_class, TOP_CLS);
    do_write(8'd0);
    chk("R3 class load 0", pwr_class, 8'd0);
    do_write(8'd2);
  endtask

  task automatic t_over_field();
    do_write(8'd16);
    chk("R4 class kept 16", pwr_class, 8'd2);
    chk("R4 err set 16", {7'd0, switch_err}, 8'd1);
    do_write(8'hFF);
    chk("R4 class kept FF", pwr_class, 8'd2);
  endtask

  task automatic t_sticky();
    do_write(8'd4);
    chk("R6 err kept over valid write", {7'd0, switch_err}, 8'd1);
    chk("R3 class after valid write with err", pwr_class, 8'd4);
    step();
    chk("R6 err sticky idle", {7'd0, switch_err}, 8'd1);
    stat_rd = 1; step();
    chk("R6 err cleared by read", {7'd0, switch_err}, 8'd0);
  endtask

  task automatic t_over_table();
    do_write(TOP_CLS + 8'd1);
    chk("R5 class kept above table", pwr_class, 8'd4);
    chk("R5 err set above table", {7'd0, switch_err}, 8'd1);
    do_write(8'd15);
    chk("R5 class kept 15", pwr_class, 8'd4);
  endtask

  task automatic t_read_collide();
    stat_rd = 1; wr_en = 1; wr_data = 8'd9; step();
    chk("R6 bad write beats read", {7'd0, switch_err}, 8'd1);
    chk("R5 class kept in collision", pwr_class, 8'd4);
  endtask

  task automatic t_idle();
    wr_data = 8'd1; step();
    repeat (3) step();
    chk("R8 class held idle", pwr_class, 8'd4);
  endtask

  task automatic t_soft();
    soft_rst = 1; step();
    chk("R2 class zero", pwr_class, 8'd0);
    chk("R2 err zero", {7'd0, switch_err}, 8'd0);
    do_write(8'd3);
    soft_rst = 1; wr_en = 1; wr_data = 8'd5; step();
    chk("R2 soft beats write", pwr_class, 8'd0);
    soft_rst = 1; wr_en = 1; wr_data = 8'd40; step();
    chk("R2 soft beats bad write", {7'd0, switch_err}, 8'd0);
  endtask

  initial begin
    t_reset();
    t_table();
    t_valid();
    t_over_field();
    t_sticky();
    t_over_table();
    t_read_collide();
    t_idle();
    t_soft();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule